// File: doc/BRIEF.md
# Preference and Deny Bus Arbiter

This block decides which of five requesters owns a shared system bus: the processor, two graphics-side ports, an internal core I/O bus and an expansion bus. A single write-only control word gives each requester a preference bit and, for all but the processor, a deny bit. A requester that is denied is never granted. A preferred requester alternates with the others: one arbitration goes to it, the next to the remaining requesters in round-robin order. Any requester that is not denied and is not preferred takes part in that rotation.

Once a grant is issued, it stays put until the owner strobes completion. It is also dropped when a programmable timeout runs out, and in that case the block raises a one-cycle bus-error pulse. Two summary flags show whether any preference bit and whether any deny bit is set in the control word. After reset every deny bit is set, so software has to clear deny bits before the peripheral buses can win the bus.

Top module: `pref_deny_arbiter`

## Requirements
- R1: After reset, gnt is 0, busErr is 0, anyPref is 0 and anyDeny is 1. All four non-processor requesters start out denied, so only the processor (gnt bit 0) can be granted until software rewrites the control word.
- R2: A write (ctrlWr high at a clock edge) loads ctrlData. Bits [22:10] hold the timeout limit. The arbitration bits decode as: bit 9 preference for the processor (index 0); bits 7/6 preference/deny for graphics port 0 (index 1); bits 5/4 preference/deny for graphics port 1 (index 2); bits 3/2 preference/deny for the core bus (index 3); bits 1/0 preference/deny for the expansion bus (index 4). Bit 8 is reserved.
- R3: gnt is one-hot or zero. A grant only goes to a requester whose req bit was high and that was not denied at the issuing edge. When the owner releases the bus, gnt is 0 for at least one cycle before the next grant.
- R4: When no preference is active, grants rotate over the eligible requesters in ascending index order, starting after the last requester that won a rotation grant. The rotation starts at index 0 after reset.
- R5: A preferred requester that is eligible wins every other arbitration. When it is the only eligible requester, it wins every arbitration.
- R6: When several preference bits are set, only the one at the lowest control-word bit position is active. The other requesters join the rotation as ordinary requesters.
- R7: With timeout limit L (L=0 acts as 1), a grant that gets no busDone stays high for exactly L cycles. In the cycle after that, gnt is 0 and busErr is 1, and busErr lasts exactly one cycle.
- R8: anyPref is the OR of the control bits under mask 0x2AA, and anyDeny is the OR under mask 0x055.
- R9: A transfer whose busDone comes before the limit runs out produces no busErr.
- R10: A control write made while a grant is held leaves that grant unchanged until its release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlData | input | 23 | Control word: timeout limit [22:10], arbitration bits [9:0] |
| req | input | 5 | Request per requester (0 processor, 1-2 graphics, 3 core, 4 expansion) |
| busDone | input | 1 | Owner completion strobe |
| gnt | output | 5 | One-hot grant |
| busErr | output | 1 | One-cycle timeout pulse |
| anyPref | output | 1 | Some preference bit is set |
| anyDeny | output | 1 | Some deny bit is set |

## Verification
The assertions assume three things about the environment. First, busDone is only raised while a grant is held. Second, a requester keeps its req high until it is granted. Third, control writes happen at cycle boundaries, with ctrlData valid whenever ctrlWr is high. The stimulus meets all three. It raises busDone only one cycle after it has seen the grant, holds each request pattern steady until the last expected grant has been completed, and drops the requests in the same cycle as that final completion. Control words are driven at the falling edge, so each write is captured whole at the following rising edge.

// File: rtl/pdarb_pkg.sv
package pdarb_pkg;
  localparam int NUM_REQ = 5;
  localparam int ARB_W   = 10;
  localparam int IDX_W   = 3;
  localparam logic [ARB_W-1:0] PREF_MASK = 10'h2AA;
  localparam logic [ARB_W-1:0] DENY_MASK = 10'h055;
  localparam logic [ARB_W-1:0] ARB_RESET = 10'h055;

  // Strobes from control to datapath
  typedef struct packed {
    logic issue;
    logic drop;
    logic prefTurn;
  } arb_strobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_OWNED = 1'b1} arb_state_e;

  // Control-word bit of each requester's preference flag
  function automatic int prefBit(input int idx);
    case (idx)
      0: prefBit = 9;
      1: prefBit = 7;
      2: prefBit = 5;
      3: prefBit = 3;
      default: prefBit = 1;
    endcase
  endfunction

  // Control-word bit of each requester's deny flag (processor has none)
  function automatic int denyBit(input int idx);
    case (idx)
      1: denyBit = 6;
      2: denyBit = 4;
      3: denyBit = 2;
      default: denyBit = 0;
    endcase
  endfunction
endpackage

// File: rtl/pdarb_dp.sv
module pdarb_dp
  import pdarb_pkg::*;
#(
  parameter int TOUT_W = 13,
  parameter logic [TOUT_W-1:0] TOUT_RESET = 13'd64,
  localparam int CTRL_W = ARB_W + TOUT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlData,
  input  logic [NUM_REQ-1:0] req,
  input  arb_strobe_t       strobe,
  output logic [NUM_REQ-1:0] gnt,
  output logic [TOUT_W-1:0] limit,
  output logic              anyElig,
  output logic              tookPref,
  output logic              anyPref,
  output logic              anyDeny,
  output logic [ARB_W-1:0]  ctrlQ
);
  logic [ARB_W-1:0]   arbQ;
  logic [TOUT_W-1:0]  limQ;
  logic [NUM_REQ-1:0] gntQ;
  logic [IDX_W-1:0]   lastRr;

  logic [NUM_REQ-1:0] prefVec, denyVec, elig, prefSel, others, rrVec;
  logic [IDX_W-1:0]   rrIdx;
  logic               rrFound, prefElig, usePref;

  // Decode the control word per requester
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_decode
    assign prefVec[i] = arbQ[prefBit(i)];
    if (i == 0) begin : g_cpu
      assign denyVec[i] = 1'b0;
    end else begin : g_dev
      assign denyVec[i] = arbQ[denyBit(i)];
    end
  end

  assign elig = req & ~denyVec;

  // Lowest control-bit position wins: higher index overrides
  always_comb begin
    prefSel = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (prefVec[i]) prefSel = NUM_REQ'(1) << i;
    end
  end

  assign prefElig = |(prefSel & elig);
  assign others   = elig & ~prefSel;
  assign usePref  = prefElig && (strobe.prefTurn || (others == '0));

  // Rotating search starting after the last rotation winner
  always_comb begin
    rrIdx   = '0;
    rrFound = 1'b0;
    for (int k = 1; k <= NUM_REQ; k++) begin
      int idx;
      idx = (int'(lastRr) + k) % NUM_REQ;
      if (!rrFound && others[idx]) begin
        rrIdx   = IDX_W'(idx);
        rrFound = 1'b1;
      end
    end
  end
  assign rrVec = rrFound ? (NUM_REQ'(1) << rrIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      arbQ   <= ARB_RESET;
      limQ   <= TOUT_RESET;
      gntQ   <= '0;
      lastRr <= IDX_W'(NUM_REQ - 1);
    end else begin
      if (ctrlWr) begin
        arbQ <= ctrlData[ARB_W-1:0];
        limQ <= ctrlData[CTRL_W-1:ARB_W];
      end
      if (strobe.issue) begin
        if (usePref) begin
          gntQ <= prefSel;
        end else begin
          gntQ   <= rrVec;
          lastRr <= rrIdx;
        end
      end else if (strobe.drop) begin
        gntQ <= '0;
      end
    end
  end

  assign gnt      = gntQ;
  assign limit    = limQ;
  assign anyElig  = |elig;
  assign tookPref = usePref;
  assign anyPref  = |(arbQ & PREF_MASK);
  assign anyDeny  = |(arbQ & DENY_MASK);
  assign ctrlQ    = arbQ;
endmodule

// File: rtl/pdarb_ctrl.sv
module pdarb_ctrl
  import pdarb_pkg::*;
#(
  parameter int TOUT_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              anyElig,
  input  logic              tookPref,
  input  logic              busDone,
  input  logic [TOUT_W-1:0] limit,
  output arb_strobe_t       strobe,
  output logic              busErr
);
  arb_state_e        state;
  logic [TOUT_W-1:0] cnt;
  logic              prefTurnQ, errQ;
  logic              issue, timeoutHit, drop;

  assign issue      = (state == ST_IDLE) && anyElig;
  assign timeoutHit = (state == ST_OWNED) && !busDone && (cnt <= TOUT_W'(1));
  assign drop       = (state == ST_OWNED) && (busDone || timeoutHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      prefTurnQ <= 1'b1;
      errQ      <= 1'b0;
    end else begin
      errQ <= timeoutHit;
      if (issue) begin
        state     <= ST_OWNED;
        cnt       <= limit;
        prefTurnQ <= !tookPref;
      end else if (drop) begin
        state <= ST_IDLE;
      end else if (state == ST_OWNED) begin
        cnt <= cnt - TOUT_W'(1);
      end
    end
  end

  assign strobe.issue    = issue;
  assign strobe.drop     = drop;
  assign strobe.prefTurn = prefTurnQ;
  assign busErr          = errQ;
endmodule

// File: rtl/pref_deny_arbiter.sv
module pref_deny_arbiter
  import pdarb_pkg::*;
#(
  parameter int TOUT_W = 13,
  parameter logic [TOUT_W-1:0] TOUT_RESET = 13'd64,
  localparam int CTRL_W = ARB_W + TOUT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWr,
  input  logic [CTRL_W-1:0]  ctrlData,
  input  logic [NUM_REQ-1:0] req,
  input  logic               busDone,
  output logic [NUM_REQ-1:0] gnt,
  output logic               busErr,
  output logic               anyPref,
  output logic               anyDeny
);
  arb_strobe_t       strobe;
  logic [TOUT_W-1:0] limit;
  logic              anyElig, tookPref;
  logic [ARB_W-1:0]  ctrlQ;

  pdarb_dp #(.TOUT_W(TOUT_W), .TOUT_RESET(TOUT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData),
    .req(req), .strobe(strobe), .gnt(gnt), .limit(limit),
    .anyElig(anyElig), .tookPref(tookPref), .anyPref(anyPref),
    .anyDeny(anyDeny), .ctrlQ(ctrlQ)
  );

  pdarb_ctrl #(.TOUT_W(TOUT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .anyElig(anyElig), .tookPref(tookPref),
    .busDone(busDone), .limit(limit), .strobe(strobe), .busErr(busErr)
  );
endmodule

// File: rtl/pdarb_checker.sv
module pdarb_checker
  import pdarb_pkg::*;
#(
  parameter int CTRL_W = 23
) (
  input logic               clk,
  input logic               rstN,
  input logic               ctrlWr,
  input logic [CTRL_W-1:0]  ctrlData,
  input logic [NUM_REQ-1:0] req,
  input logic [NUM_REQ-1:0] gnt,
  input logic               busErr,
  input logic               anyPref,
  input logic               anyDeny,
  input logic [ARB_W-1:0]   ctrlQ
);
  logic [NUM_REQ-1:0] deniedNow;
  assign deniedNow = {ctrlQ[0], ctrlQ[2], ctrlQ[4], ctrlQ[6], 1'b0};

  assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gnt));

  assert_gnt_requested_R3: assert property (@(posedge clk) disable iff (!rstN)
    (gnt != '0 && $past(gnt) == '0) |-> (($past(req) & gnt) != '0));

  assert_gnt_not_denied_R1: assert property (@(posedge clk) disable iff (!rstN)
    (gnt != '0 && $past(gnt) == '0) |-> ((gnt & $past(deniedNow)) == '0));

  assert_gnt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(gnt) != '0 && gnt != '0) |-> (gnt == $past(gnt)));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);

  assert_err_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (gnt == '0 && $past(gnt) != '0));

  assert_flag_pref_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWr) |-> (anyPref == |($past(ctrlData[ARB_W-1:0]) & PREF_MASK)));

  assert_flag_deny_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWr) |-> (anyDeny == |($past(ctrlData[ARB_W-1:0]) & DENY_MASK)));
endmodule

bind pref_deny_arbiter pdarb_checker #(.CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData), .req(req),
  .gnt(gnt), .busErr(busErr), .anyPref(anyPref), .anyDeny(anyDeny),
  .ctrlQ(ctrlQ)
);

// File: tb/pref_deny_arbiter_tb.sv
`timescale 1ns/1ps
module pref_deny_arbiter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWr = 1'b0;
  logic [22:0] ctrlData = '0;
  logic [4:0]  req = '0;
  logic        busDone = 1'b0;
  logic [4:0]  gnt;
  logic        busErr, anyPref, anyDeny;

  int    nChecks = 0;
  int    nFails = 0;
  int    errCount = 0;
  int    expQ[$];
  string curTag = "R3";
  bit    finished = 0;

  always #2.5 clk = ~clk;

  pref_deny_arbiter u_dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlData(ctrlData), .req(req),
    .busDone(busDone), .gnt(gnt), .busErr(busErr), .anyPref(anyPref),
    .anyDeny(anyDeny)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every new grant
  initial begin
    logic [4:0] prevGnt = '0;
    forever begin
      @(negedge clk);
      if (rstN && gnt != '0 && prevGnt == '0) begin
        if (expQ.size() == 0) begin
          check(1'b0, {curTag, " unexpected grant"}, int'(gnt), 0);
        end else begin
          int e;
          e = expQ.pop_front();
          check(gnt == (5'b1 << e), curTag, int'(gnt), 1 << e);
        end
      end
      if (busErr) errCount++;
      prevGnt = gnt;
    end
  end

  task automatic writeCtrl(input logic [9:0] arb, input logic [12:0] lim);
    @(negedge clk);
    ctrlWr   = 1'b1;
    ctrlData = {lim, arb};
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  // Driver: completes n transfers, dropping requests with the last one
  task automatic runXfers(input logic [4:0] r, input int n, input string tag);
    curTag = tag;
    req = r;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (gnt == '0);
      busDone = 1'b1;
      if (i == n - 1) req = '0;
      @(negedge clk);
      busDone = 1'b0;
      check(gnt == '0, "R3 idle gap after release", int'(gnt), 0);
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, {tag, " all expected grants seen"}, expQ.size(), 0);
  endtask

  task automatic timeoutRun(input logic [12:0] lim, input int expCycles);
    int cnt;
    writeCtrl(10'h000, lim);
    curTag = "R7";
    expQ.push_back(3);
    req = 5'b01000;
    do @(negedge clk); while (gnt == '0);
    req = '0;
    cnt = 1;
    @(negedge clk);
    while (gnt != '0) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == expCycles, "R7 grant length before timeout", cnt, expCycles);
    check(busErr == 1'b1, "R7 busErr after expiry", int'(busErr), 1);
    @(negedge clk);
    check(busErr == 1'b0, "R7 busErr one cycle", int'(busErr), 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(gnt == '0, "R1 gnt reset", int'(gnt), 0);
    check(busErr == 1'b0, "R1 busErr reset", int'(busErr), 0);
    check(anyPref == 1'b0, "R1 anyPref reset", int'(anyPref), 0);
    check(anyDeny == 1'b1, "R1 anyDeny reset", int'(anyDeny), 1);

    // R1: only the processor can win while others are denied
    expQ = '{0, 0, 0};
    runXfers(5'b11111, 3, "R1");

    // R2/R8: clear all deny bits; R4 rotation
    writeCtrl(10'h000, 13'd64);
    check(anyDeny == 1'b0 && anyPref == 1'b0, "R8 flags after clear", {anyPref, anyDeny}, 0);
    expQ = '{1, 2, 3, 4, 0, 1};
    runXfers(5'b11111, 6, "R4");

    // R5 preference for graphics port 1 (bit 5)
    writeCtrl(10'h020, 13'd64);
    check(anyPref == 1'b1, "R8 anyPref set", int'(anyPref), 1);
    expQ = '{2, 3, 2, 4, 2, 0, 2, 1};
    runXfers(5'b11111, 8, "R5");
    expQ = '{2, 2, 2};
    runXfers(5'b00100, 3, "R5 sole requester");

    // R6: expansion (bit 1) and processor (bit 9) both preferred
    writeCtrl(10'h202, 13'd64);
    check({anyPref, anyDeny} == 2'b10, "R8 flags 0x202", {anyPref, anyDeny}, 2);
    expQ = '{2, 4, 3, 4, 0};
    runXfers(5'b11111, 5, "R6");

    // R2: deny graphics port 0 (bit 6) and core (bit 2)
    writeCtrl(10'h044, 13'd64);
    check({anyPref, anyDeny} == 2'b01, "R8 flags 0x044", {anyPref, anyDeny}, 1);
    expQ = '{2, 4, 0, 2};
    runXfers(5'b11111, 4, "R2");

    // R9: every transfer so far completed early
    check(errCount == 0, "R9 no busErr on early completion", errCount, 0);

    // R10: write during a held grant
    writeCtrl(10'h000, 13'd40);
    curTag = "R10";
    expQ.push_back(1);
    req = 5'b00010;
    do @(negedge clk); while (gnt == '0);
    req = '0;
    writeCtrl(10'h040, 13'd40);
    @(negedge clk);
    check(gnt == 5'b00010, "R10 grant kept across write", int'(gnt), 2);
    busDone = 1'b1;
    @(negedge clk);
    busDone = 1'b0;
    check(gnt == '0, "R10 release after done", int'(gnt), 0);

    // R7 timeout, then limit zero acting as one
    timeoutRun(13'd5, 5);
    timeoutRun(13'd0, 1);
    check(errCount == 2, "R7 busErr pulse count", errCount, 2);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);

    summary();
  end
endmodule